// File: doc/BRIEF.md
# Paged DRAM Strobe Sequencer

This block drives an asynchronous DRAM whose address pins are shared between row and column. A client presents a flat word address with a read or write flag. The sequencer splits the address into a row index (upper bits) and a column index (lower bits). It places the row on the pins and pulls the row strobe low, waits a set number of cycles, then places the column on the pins and pulls the column strobe low. After a second wait it either captures read data or finishes the write.

The row stays open after an access. A later request to the same row goes straight to a column cycle. A request to a different row first releases the row strobe for a precharge time and then opens the new row. An internal timer asks for a refresh at a fixed interval. The refresh strobes one row from a rolling row counter with the column strobe held high. It wins over new requests once the access in flight has finished, and it closes any open page.

Top module: `dram_page_ctrl`

## Requirements
- R1: After reset, and whenever no row is open, `dram_ras_n`, `dram_cas_n` and `dram_we_n` are high, `dram_dq_oe` is low and `req_ready` is high unless a refresh is due.
- R2: The row is `req_addr[ROW_W+COL_W-1:COL_W]` and the column is `req_addr[COL_W-1:0]`. Each is zero-extended onto `dram_addr`: the row is on the pins when RAS falls, and the column is on the pins while CAS is low.
- R3: CAS falls no sooner than T_RCD cycles after RAS falls. A read to a closed bank raises `rd_valid` T_RCD+T_CAS cycles after the clock edge that accepts it.
- R4: CAS stays low for T_CAS cycles and read data is sampled at the end of that window. A read that hits the open row raises `rd_valid` T_CAS cycles after acceptance.
- R5: A write holds `dram_we_n` low and `dram_dq_oe` high during its CAS window and drives `req_wdata` on `dram_dq_out`. A later read of that address returns the written value.
- R6: An access to the row that is already open produces no falling edge on RAS.
- R7: RAS stays high for at least T_PRE cycles before each fall. A read to a different row while a page is open raises `rd_valid` T_PRE+T_RCD+T_CAS cycles after acceptance.
- R8: With no traffic, a refresh happens every REF_INTERVAL cycles. Each refresh holds RAS low for exactly T_RFSH cycles with CAS high. Refreshed rows run 0, 1, 2, … modulo 2^ROW_W.
- R9: While a refresh is due, `req_ready` is low. The refresh closes the open page, so the next access pays the closed-bank latency.
- R10: `rd_valid` pulses for exactly one cycle per read and never for a write.
- R11: CAS is low only while RAS is low, and WE is low only while CAS is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Flat word address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Request accepted on this edge when high with req_valid |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | DATA_W | Read data |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_dq_out | output | DATA_W | Data driven to the array |
| dram_dq_oe | output | 1 | Data output enable |
| dram_dq_in | input | DATA_W | Data returned by the array |

## Verification
The bench builds the block with a 16-row by 8-column array of bytes, waits of two cycles for row-to-column, column-to-data and precharge, a three-cycle refresh and a 300-cycle refresh interval. With these small waits the three latency classes (page hit, closed bank, row miss) are distinct and can be measured exactly. The short interval lets refreshes land both between directed accesses and inside random traffic. With few rows, the random stream often reopens and hits pages, and the refresh row counter wraps within a single run.

// File: rtl/dram_page_pkg.sv
package dram_page_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_COL,
        ST_PAGE,
        ST_PRE,
        ST_RFSH
    } seq_state_e;

endpackage

// File: rtl/dram_addr_split.sv
module dram_addr_split #(
    parameter int ROW_W = 12,
    parameter int COL_W = 9,
    parameter int PIN_W = 12
) (
    input  logic [ROW_W+COL_W-1:0] addr,
    output logic [ROW_W-1:0]       row_idx,
    output logic [PIN_W-1:0]       row_pins,
    output logic [PIN_W-1:0]       col_pins
);

    always_comb begin
        row_idx  = addr[ROW_W+COL_W-1:COL_W];
        row_pins = '0;
        row_pins[ROW_W-1:0] = addr[ROW_W+COL_W-1:COL_W];
        col_pins = '0;
        col_pins[COL_W-1:0] = addr[COL_W-1:0];
    end

endmodule

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
    parameter int REF_INTERVAL = 1000,
    parameter int ROW_W        = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack,
    output logic             pending,
    output logic [ROW_W-1:0] ref_row
);

    localparam int TW = (REF_INTERVAL < 2) ? 1 : $clog2(REF_INTERVAL);

    typedef struct packed {
        logic [TW-1:0]    tick;
        logic             pend;
        logic [ROW_W-1:0] row;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (ack) begin
            tmr_d.pend = 1'b0;
            tmr_d.row  = tmr_q.row + 1'b1;
        end
        if (tmr_q.tick == TW'(REF_INTERVAL - 1)) begin
            tmr_d.tick = '0;
            tmr_d.pend = 1'b1;
        end else begin
            tmr_d.tick = tmr_q.tick + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign pending = tmr_q.pend;
    assign ref_row = tmr_q.row;

    a_r8_request_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q.tick == TW'(REF_INTERVAL - 1)) |=> pending);

    a_r8_row_steps_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> (ref_row == $past(ref_row) + 1'b1));

endmodule

// File: rtl/dram_seq_fsm.sv
module dram_seq_fsm
    import dram_page_pkg::*;
#(
    parameter int ROW_W  = 12,
    parameter int COL_W  = 9,
    parameter int PIN_W  = 12,
    parameter int DATA_W = 8,
    parameter int T_RCD  = 3,
    parameter int T_CAS  = 3,
    parameter int T_PRE  = 3,
    parameter int T_RFSH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ROW_W-1:0]  req_row_idx,
    input  logic [PIN_W-1:0]  req_row_pins,
    input  logic [PIN_W-1:0]  req_col_pins,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    input  logic              ref_pend,
    input  logic [ROW_W-1:0]  ref_row,
    output logic              ref_ack,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [PIN_W-1:0]  addr_pins,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    input  logic [DATA_W-1:0] dq_in,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    localparam int T_MAX_A = (T_RCD > T_CAS) ? T_RCD : T_CAS;
    localparam int T_MAX_B = (T_PRE > T_RFSH) ? T_PRE : T_RFSH;
    localparam int T_MAX   = (T_MAX_A > T_MAX_B) ? T_MAX_A : T_MAX_B;
    localparam int CNT_W   = $clog2(T_MAX + 1);
    localparam int RUN_W   = $clog2(T_MAX + 2) + 1;

    typedef struct packed {
        seq_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic [ROW_W-1:0]  open_row;
        logic [PIN_W-1:0]  row_pins;
        logic [PIN_W-1:0]  col_pins;
        logic [PIN_W-1:0]  ref_pins;
        logic              wr;
        logic [DATA_W-1:0] wdata;
        logic              pend;
        logic              rd_valid;
        logic [DATA_W-1:0] rd_data;
        logic              ras_n;
        logic              cas_n;
        logic              we_n;
        logic              oe;
        logic [PIN_W-1:0]  addr;
    } seq_t;

    seq_t s_d, s_q;
    logic accept;
    logic [PIN_W-1:0] ref_pins_ext;

    always_comb begin
        ref_pins_ext = '0;
        ref_pins_ext[ROW_W-1:0] = ref_row;
    end

    always_comb begin
        s_d        = s_q;
        s_d.rd_valid = 1'b0;
        ref_ack    = 1'b0;
        req_ready  = ((s_q.state == ST_IDLE) || (s_q.state == ST_PAGE)) && !ref_pend;
        accept     = req_valid && req_ready;

        if (accept) begin
            s_d.wr       = req_write;
            s_d.wdata    = req_wdata;
            s_d.col_pins = req_col_pins;
        end

        case (s_q.state)
            ST_IDLE: begin
                if (ref_pend) begin
                    s_d.state    = ST_RFSH;
                    s_d.cnt      = CNT_W'(T_RFSH - 1);
                    s_d.ref_pins = ref_pins_ext;
                    ref_ack      = 1'b1;
                end else if (accept) begin
                    s_d.state    = ST_ROW;
                    s_d.cnt      = CNT_W'(T_RCD - 1);
                    s_d.open_row = req_row_idx;
                    s_d.row_pins = req_row_pins;
                end
            end
            ST_ROW: begin
                if (s_q.cnt == '0) begin
                    s_d.state = ST_COL;
                    s_d.cnt   = CNT_W'(T_CAS - 1);
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            ST_COL: begin
                if (s_q.cnt == '0) begin
                    s_d.state = ST_PAGE;
                    if (!s_q.wr) begin
                        s_d.rd_data  = dq_in;
                        s_d.rd_valid = 1'b1;
                    end
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            ST_PAGE: begin
                if (ref_pend) begin
                    s_d.state = ST_PRE;
                    s_d.cnt   = CNT_W'(T_PRE - 1);
                    s_d.pend  = 1'b0;
                end else if (accept) begin
                    if (req_row_idx == s_q.open_row) begin
                        s_d.state = ST_COL;
                        s_d.cnt   = CNT_W'(T_CAS - 1);
                    end else begin
                        s_d.state    = ST_PRE;
                        s_d.cnt      = CNT_W'(T_PRE - 1);
                        s_d.pend     = 1'b1;
                        s_d.open_row = req_row_idx;
                        s_d.row_pins = req_row_pins;
                    end
                end
            end
            ST_PRE: begin
                if (s_q.cnt == '0) begin
                    if (s_q.pend) begin
                        s_d.state = ST_ROW;
                        s_d.cnt   = CNT_W'(T_RCD - 1);
                        s_d.pend  = 1'b0;
                    end else if (ref_pend) begin
                        s_d.state    = ST_RFSH;
                        s_d.cnt      = CNT_W'(T_RFSH - 1);
                        s_d.ref_pins = ref_pins_ext;
                        ref_ack      = 1'b1;
                    end else begin
                        s_d.state = ST_IDLE;
                    end
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            ST_RFSH: begin
                if (s_q.cnt == '0) begin
                    s_d.state = ST_PRE;
                    s_d.cnt   = CNT_W'(T_PRE - 1);
                    s_d.pend  = 1'b0;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            default: s_d.state = ST_IDLE;
        endcase

        s_d.ras_n = !((s_d.state == ST_ROW) || (s_d.state == ST_COL) ||
                      (s_d.state == ST_PAGE) || (s_d.state == ST_RFSH));
        s_d.cas_n = (s_d.state != ST_COL);
        s_d.we_n  = !((s_d.state == ST_COL) && s_d.wr);
        s_d.oe    = (s_d.state == ST_COL) && s_d.wr;
        if (s_d.state == ST_COL)       s_d.addr = s_d.col_pins;
        else if (s_d.state == ST_RFSH) s_d.addr = s_d.ref_pins;
        else                           s_d.addr = s_d.row_pins;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.state <= ST_IDLE;
            s_q.ras_n <= 1'b1;
            s_q.cas_n <= 1'b1;
            s_q.we_n  <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign ras_n     = s_q.ras_n;
    assign cas_n     = s_q.cas_n;
    assign we_n      = s_q.we_n;
    assign dq_oe     = s_q.oe;
    assign dq_out    = s_q.wdata;
    assign addr_pins = s_q.addr;
    assign rd_valid  = s_q.rd_valid;
    assign rd_data   = s_q.rd_data;

    // Checker counters: length of the current RAS low / high run.
    logic [RUN_W-1:0] run_low_q, run_high_q;
    localparam logic [RUN_W-1:0] RUN_SAT = RUN_W'(T_MAX + 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_low_q  <= '0;
            run_high_q <= RUN_SAT;
        end else if (!ras_n) begin
            run_high_q <= '0;
            run_low_q  <= (run_low_q == RUN_SAT) ? RUN_SAT : run_low_q + 1'b1;
        end else begin
            run_low_q  <= '0;
            run_high_q <= (run_high_q == RUN_SAT) ? RUN_SAT : run_high_q + 1'b1;
        end
    end

    a_r3_row_to_col_wait: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> (run_low_q >= RUN_W'(T_RCD)));

    a_r7_precharge_wait: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (run_high_q >= RUN_W'(T_PRE)));

    a_r11_cas_inside_ras: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ras_n);

    a_r11_we_inside_cas: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> !cas_n);

    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    a_r9_ready_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pend |-> !req_ready);

endmodule

// File: rtl/dram_page_ctrl.sv
module dram_page_ctrl #(
    parameter int ROW_W        = 12,
    parameter int COL_W        = 9,
    parameter int DATA_W       = 8,
    parameter int T_RCD        = 3,
    parameter int T_CAS        = 3,
    parameter int T_PRE        = 3,
    parameter int T_RFSH       = 4,
    parameter int REF_INTERVAL = 1000,
    localparam int ADDR_W      = ROW_W + COL_W,
    localparam int PIN_W       = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_we_n,
    output logic [PIN_W-1:0]  dram_addr,
    output logic [DATA_W-1:0] dram_dq_out,
    output logic              dram_dq_oe,
    input  logic [DATA_W-1:0] dram_dq_in
);

    logic [ROW_W-1:0] row_idx;
    logic [PIN_W-1:0] row_pins, col_pins;
    logic             ref_pend, ref_ack;
    logic [ROW_W-1:0] ref_row;

    dram_addr_split #(
        .ROW_W(ROW_W), .COL_W(COL_W), .PIN_W(PIN_W)
    ) i_split (
        .addr     (req_addr),
        .row_idx  (row_idx),
        .row_pins (row_pins),
        .col_pins (col_pins)
    );

    dram_refresh_timer #(
        .REF_INTERVAL(REF_INTERVAL), .ROW_W(ROW_W)
    ) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .ack     (ref_ack),
        .pending (ref_pend),
        .ref_row (ref_row)
    );

    dram_seq_fsm #(
        .ROW_W(ROW_W), .COL_W(COL_W), .PIN_W(PIN_W), .DATA_W(DATA_W),
        .T_RCD(T_RCD), .T_CAS(T_CAS), .T_PRE(T_PRE), .T_RFSH(T_RFSH)
    ) i_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_row_idx  (row_idx),
        .req_row_pins (row_pins),
        .req_col_pins (col_pins),
        .req_wdata    (req_wdata),
        .req_ready    (req_ready),
        .ref_pend     (ref_pend),
        .ref_row      (ref_row),
        .ref_ack      (ref_ack),
        .ras_n        (dram_ras_n),
        .cas_n        (dram_cas_n),
        .we_n         (dram_we_n),
        .addr_pins    (dram_addr),
        .dq_out       (dram_dq_out),
        .dq_oe        (dram_dq_oe),
        .dq_in        (dram_dq_in),
        .rd_valid     (rd_valid),
        .rd_data      (rd_data)
    );

endmodule

// File: tb/test_dram_page_ctrl.sv
module test_dram_page_ctrl;

    localparam int ROW_W = 4, COL_W = 3, DATA_W = 8;
    localparam int T_RCD = 2, T_CAS = 2, T_PRE = 2, T_RFSH = 3;
    localparam int REF_INTERVAL = 300;
    localparam int ADDR_W = ROW_W + COL_W;
    localparam int PIN_W = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int WORDS = 1 << ADDR_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic req_ready, rd_valid;
    logic [DATA_W-1:0] rd_data;
    logic dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe;
    logic [PIN_W-1:0] dram_addr;
    logic [DATA_W-1:0] dram_dq_out, dram_dq_in;

    always #10 clk = ~clk;

    dram_page_ctrl #(
        .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
        .T_RCD(T_RCD), .T_CAS(T_CAS), .T_PRE(T_PRE), .T_RFSH(T_RFSH),
        .REF_INTERVAL(REF_INTERVAL)
    ) i_dram_page_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rd_valid(rd_valid), .rd_data(rd_data), .dram_ras_n(dram_ras_n),
        .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_addr(dram_addr),
        .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
    );

    int n_tests = 0, n_fail = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- array model and pin monitor ----------------
    logic [DATA_W-1:0] model_mem [WORDS];
    logic [DATA_W-1:0] shadow    [WORDS];
    logic [ROW_W-1:0]  mdl_row = '0;
    assign dram_dq_in = model_mem[{mdl_row, dram_addr[COL_W-1:0]}];

    bit prev_ras = 1'b1, prev_cas = 1'b1, prev_rdv = 1'b0, saw_cas = 1'b0;
    int high_run = 100, low_run = 0;
    int ras_falls = 0, ref_events = 0, rdv_pulses = 0;
    int exp_ref_row = 0;
    int last_row_pin = 0, last_col_pin = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_ras && !dram_ras_n) begin
                chk(high_run >= T_PRE, "R7", "precharge cycles before RAS fall", high_run, T_PRE);
                ras_falls++;
                mdl_row = dram_addr[ROW_W-1:0];
                last_row_pin = int'(dram_addr);
                saw_cas = 1'b0;
            end
            if (prev_cas && !dram_cas_n) begin
                chk(low_run >= T_RCD, "R3", "RAS-to-CAS cycles", low_run, T_RCD);
                last_col_pin = int'(dram_addr);
            end
            if (!dram_cas_n) begin
                saw_cas = 1'b1;
                chk(!dram_ras_n, "R11", "CAS low while RAS high", int'(dram_ras_n), 0);
            end
            if (!dram_we_n)
                chk(!dram_cas_n, "R11", "WE low outside CAS", int'(dram_cas_n), 0);
            if (!dram_cas_n && !dram_we_n && dram_dq_oe)
                model_mem[{mdl_row, dram_addr[COL_W-1:0]}] = dram_dq_out;
            if (!prev_ras && dram_ras_n && !saw_cas) begin
                chk(low_run == T_RFSH, "R8", "refresh RAS low cycles", low_run, T_RFSH);
                chk(int'(mdl_row) == exp_ref_row, "R8", "refresh row", int'(mdl_row), exp_ref_row);
                exp_ref_row = (int'(mdl_row) + 1) % (1 << ROW_W);
                ref_events++;
            end
            if (rd_valid) begin
                if (prev_rdv)
                    chk(1'b0, "R10", "rd_valid longer than one cycle", 2, 1);
                else
                    rdv_pulses++;
            end
            if (!dram_ras_n) begin low_run++; high_run = 0; end
            else begin high_run++; low_run = 0; end
            prev_ras = dram_ras_n;
            prev_cas = dram_cas_n;
            prev_rdv = rd_valid;
        end
    end

    // ---------------- stimulus ----------------
    int reads_issued = 0;

    task automatic access(input bit wr, input int row, input int col,
                          input logic [DATA_W-1:0] wd, output int lat,
                          output logic [DATA_W-1:0] rdat);
        int acc;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = ADDR_W'((row << COL_W) | col);
        req_wdata = wd;
        while (!req_ready) @(negedge clk);
        acc = cyc + 1;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0;
        rdat = '0;
        if (wr) begin
            shadow[(row << COL_W) | col] = wd;
        end else begin
            reads_issued++;
            while (!rd_valid) @(negedge clk);
            lat = cyc - acc;
            rdat = rd_data;
        end
    endtask

    task automatic wait_refresh();
        int start = ref_events;
        while (ref_events == start) @(negedge clk);
        repeat (T_PRE + 2) @(negedge clk);
    endtask

    initial begin
        int lat, rf0, r0;
        logic [DATA_W-1:0] d;
        for (int i = 0; i < WORDS; i++) begin
            model_mem[i] = '0;
            shadow[i] = '0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(dram_ras_n && dram_cas_n && dram_we_n && !dram_dq_oe, "R1",
            "strobes idle after reset", {dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe}, 4'b1110);
        chk(req_ready && !rd_valid, "R1", "ready after reset", {req_ready, rd_valid}, 2'b10);

        wait_refresh();
        chk(dram_ras_n && dram_cas_n && dram_we_n && !dram_dq_oe, "R1",
            "strobes idle after refresh", {dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe}, 4'b1110);

        // R3 closed-bank read, R2 pin split
        access(1'b0, 5, 3, '0, lat, d);
        chk(lat == T_RCD + T_CAS, "R3", "closed-bank read latency", lat, T_RCD + T_CAS);
        chk(last_row_pin == 5, "R2", "row on pins at RAS fall", last_row_pin, 5);
        chk(last_col_pin == 3, "R2", "column on pins at CAS fall", last_col_pin, 3);

        // R5/R6 write in open page
        r0 = ras_falls;
        access(1'b1, 5, 6, 8'hA5, lat, d);
        access(1'b0, 5, 6, '0, lat, d);
        chk(lat == T_CAS, "R4", "page-hit read latency", lat, T_CAS);
        chk(d == 8'hA5, "R5", "write then read back", int'(d), 8'hA5);
        chk(ras_falls == r0, "R6", "no RAS fall on page hits", ras_falls - r0, 0);
        chk(last_col_pin == 6, "R2", "column pins on hit", last_col_pin, 6);

        // R7 row miss
        access(1'b0, 9, 1, '0, lat, d);
        chk(lat == T_PRE + T_RCD + T_CAS, "R7", "row-miss read latency", lat, T_PRE + T_RCD + T_CAS);
        chk(last_row_pin == 9, "R2", "new row on pins", last_row_pin, 9);

        // R9 refresh closes the page
        wait_refresh();
        access(1'b0, 9, 1, '0, lat, d);
        chk(lat == T_RCD + T_CAS, "R9", "access after refresh pays closed latency", lat, T_RCD + T_CAS);

        // R8 refresh rate when idle
        rf0 = ref_events;
        repeat (3 * REF_INTERVAL) @(negedge clk);
        chk((ref_events - rf0) >= 2 && (ref_events - rf0) <= 4, "R8",
            "refreshes in 3 intervals", ref_events - rf0, 3);

        // Random traffic with a fixed seed, checked against the shadow array
        void'($urandom(32'h5EED_0123));
        for (int k = 0; k < 400; k++) begin
            bit wr = $urandom_range(0, 1) == 1;
            int row = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 15) : $urandom_range(0, 2);
            int col = $urandom_range(0, 7);
            logic [DATA_W-1:0] wd = DATA_W'($urandom);
            access(wr, row, col, wd, lat, d);
            if (!wr)
                chk(d == shadow[(row << COL_W) | col], "R5", "random read data",
                    int'(d), int'(shadow[(row << COL_W) | col]));
        end
        repeat (10) @(negedge clk);
        chk(rdv_pulses == reads_issued, "R10", "rd_valid pulses equal reads", rdv_pulses, reads_issued);
        chk(ref_events >= 4, "R8", "refreshes occurred during traffic", ref_events, 4);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected completion", 150000);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule